// File: doc/BRIEF.md
# SPI Target with Selectable Command Set

This block is an SPI target (slave) that sits behind four external pins and serves one of four operations per chip-select window: write a status word, write into a local bit buffer, read from that buffer, or read a status word. The master first shifts an 8-bit opcode. The opcode is compared either against four fixed codes or against four codes held in configuration inputs, depending on one select input.

Buffer operations follow the opcode with an address of programmable length. Any of the four operations may insert a programmable number of idle (dummy) SCLK cycles before data moves. The data length of each buffer operation is programmable down to a single bit. Every completed operation sends a one-cycle interrupt pulse on its own line and on a shared "any operation" line, and each line can be masked. The block also shows the most recent opcode and a wrapping count of completed operations.

SCLK, CS and MOSI are synchronised into the system clock domain, so the SCLK frequency must stay well below the system clock. Data moves MSB first in SPI mode 0: the bus idles with SCLK low, MOSI is taken on the rising edge and MISO changes after the falling edge.

Top module: `spis_target`

## Requirements
- R1: While `spi_cs_n` is low, the target samples MOSI on each rising SCLK edge, MSB first. The first 8 bits form the opcode. MISO changes only after a falling SCLK edge, or when chip select goes high.
- R2: With `cmd_prog_en` low, the opcodes are fixed: 1 selects write-status, 2 selects write-buffer, 3 selects read-buffer and 4 selects read-status.
- R3: With `cmd_prog_en` high, the opcodes come from `cmd_codes_i`. Byte k of that input (bits 8k+7..8k) holds the code for operation k, where k=0 is write-status, k=1 is write-buffer, k=2 is read-buffer and k=3 is read-status. If two codes are equal, the lower k wins.
- R4: A buffer operation is followed by `*_alen_i`+1 address bits, MSB first. The low log2(BUF_BYTES) bits of the address select the starting byte. Status operations carry no address.
- R5: If `dummy_en_i[k]` is set, operation k skips `dummy_len_i[8k+7:8k]`+1 SCLK cycles between its address (or opcode) and its data. MOSI is ignored during these cycles.
- R6: Write-buffer stores `wrbuf_dlen_i`+1 bits. Stream bit j goes to byte (start + j/8) mod BUF_BYTES, at bit position 7-(j mod 8). Buffer bits that are not written keep their value.
- R7: Read-buffer returns `rdbuf_dlen_i`+1 bits on MISO, using the same bit mapping as R6.
- R8: Write-status shifts in STAT_W bits, MSB first. `wr_status_o` takes the new value only once all STAT_W bits have arrived.
- R9: Read-status sends STAT_W bits, MSB first. The source is `wr_status_o` when `sta_sel_wr_i`=1 and `rd_status_i` when it is 0.
- R10: When operation k completes, `irq_o[k]` pulses for one cycle if `int_en_i[k]` is set. `irq_o[4]` pulses for any completed operation if `int_en_i[4]` is set. Bit order for k: 0 write-status, 1 write-buffer, 2 read-buffer, 3 read-status.
- R11: `last_cmd_o` holds the most recent opcode byte, whether it is valid or not. `op_count_o` counts completed operations modulo 2^CNT_W. Both reset to 0.
- R12: If chip select rises before the last data bit, the operation is aborted. No interrupt is raised, the count and `wr_status_o` stay unchanged, and the next low window starts a fresh opcode.
- R13: An opcode that matches no active code is ignored until chip select rises. It raises no interrupt, leaves the count and status unchanged, and keeps MISO low.
- R14: MISO is 0 from reset and at every time the target is not shifting out read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| cmd_prog_en | input | 1 | 1: use `cmd_codes_i`; 0: use the fixed codes 1..4 |
| cmd_codes_i | input | 32 | Four programmable opcodes, one byte per operation |
| dummy_en_i | input | 4 | Dummy-phase enable, one bit per operation |
| dummy_len_i | input | 32 | Dummy length minus one, one byte per operation |
| wrbuf_alen_i | input | 6 | Write-buffer address bits minus one |
| rdbuf_alen_i | input | 6 | Read-buffer address bits minus one |
| wrbuf_dlen_i | input | 24 | Write-buffer data bits minus one |
| rdbuf_dlen_i | input | 24 | Read-buffer data bits minus one |
| sta_sel_wr_i | input | 1 | Read-status source: 1 written status, 0 local status |
| rd_status_i | input | STAT_W | Local status word returned by read-status |
| int_en_i | input | 5 | Interrupt enables, one per line |
| irq_o | output | 5 | One-cycle done pulses |
| wr_status_o | output | STAT_W | Status word written by the master |
| last_cmd_o | output | 8 | Most recent opcode byte |
| op_count_o | output | CNT_W | Count of completed operations |

## Verification
The hardest situations to reach from the ports are those where the byte pointer wraps past the end of the buffer while a transfer is partly done, or where chip select rises in the middle of a data phase. The bench reaches both with a bit-level SPI driver. The driver can stop after any number of bits, so the bench starts writes near the top byte and ends a write-status window halfway through its data. It then checks through a follow-up read-buffer or read-status that the stored state matches its own model. Dummy phases are filled with ones, so bits that are wrongly sampled during a dummy phase would show up in the status value that is later read back.

// File: rtl/spis_pkg.sv
package spis_pkg;
  typedef enum logic [1:0] {
    OP_WRSTA = 2'd0,
    OP_WRBUF = 2'd1,
    OP_RDBUF = 2'd2,
    OP_RDSTA = 2'd3
  } spis_op_e;

  typedef enum logic [2:0] {
    ST_CMD   = 3'd0,
    ST_ADDR  = 3'd1,
    ST_DUMMY = 3'd2,
    ST_DATA  = 3'd3,
    ST_END   = 3'd4
  } spis_st_e;

  function automatic logic op_has_addr(spis_op_e op);
    return (op == OP_WRBUF) || (op == OP_RDBUF);
  endfunction

  function automatic logic op_is_read(spis_op_e op);
    return (op == OP_RDBUF) || (op == OP_RDSTA);
  endfunction
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/spis_decode.sv
module spis_decode
  import spis_pkg::*;
#(
  parameter int NUM_OPS = 4
) (
  input  logic [7:0]           code_i,
  input  logic                 prog_en_i,
  input  logic [NUM_OPS*8-1:0] prog_codes_i,
  output logic                 hit_o,
  output spis_op_e             op_o
);
  logic [NUM_OPS-1:0] match;

  // One comparator per operation; fixed code of operation k is k+1.
  for (genvar k = 0; k < NUM_OPS; k++) begin : g_cmp
    logic [7:0] want;
    assign want     = prog_en_i ? prog_codes_i[8*k +: 8] : 8'(k + 1);
    assign match[k] = (code_i == want);
  end

  // Lowest-numbered operation wins when codes collide.
  always_comb begin
    hit_o = |match;
    op_o  = OP_WRSTA;
    for (int k = NUM_OPS - 1; k >= 0; k--) begin
      if (match[k]) op_o = spis_op_e'(k[1:0]);
    end
  end
endmodule

// File: rtl/spis_target.sv
module spis_target
  import spis_pkg::*;
#(
  parameter int BUF_BYTES   = 32,
  parameter int STAT_W      = 32,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              cmd_prog_en,
  input  logic [31:0]       cmd_codes_i,
  input  logic [3:0]        dummy_en_i,
  input  logic [31:0]       dummy_len_i,
  input  logic [5:0]        wrbuf_alen_i,
  input  logic [5:0]        rdbuf_alen_i,
  input  logic [23:0]       wrbuf_dlen_i,
  input  logic [23:0]       rdbuf_dlen_i,
  input  logic              sta_sel_wr_i,
  input  logic [STAT_W-1:0] rd_status_i,
  input  logic [4:0]        int_en_i,
  output logic [4:0]        irq_o,
  output logic [STAT_W-1:0] wr_status_o,
  output logic [7:0]        last_cmd_o,
  output logic [CNT_W-1:0]  op_count_o
);
  localparam int ADDR_W   = $clog2(BUF_BYTES);
  localparam int BUF_BITS = BUF_BYTES * 8;
  localparam int PTR_W    = ADDR_W + 3;
  localparam int LEN_W    = 24;
  localparam int SW       = $clog2(STAT_W);

  // Stream bit k of a transfer starting at byte 'start' (MSB first per byte).
  function automatic logic [PTR_W-1:0] buf_index(input logic [ADDR_W-1:0] start,
                                                 input logic [LEN_W-1:0] k);
    logic [ADDR_W-1:0] byte_n;
    byte_n = start + k[ADDR_W+2:3];
    return {byte_n, ~k[2:0]};
  endfunction

  // ---------------- pin synchronisation and edges ----------------
  logic sclk_s, cs_s, mosi_s, sclk_d;
  spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({spi_sclk, spi_cs_n, spi_mosi}),
    .q_o({sclk_s, cs_s, mosi_s})
  );
  logic rise_w, fall_w;
  assign rise_w = sclk_s & ~sclk_d & ~cs_s;
  assign fall_w = ~sclk_s & sclk_d & ~cs_s;

  // ---------------- state ----------------
  spis_st_e          state_q;
  spis_op_e          op_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [STAT_W-1:0] sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BUF_BITS-1:0] buf_q;
  logic [STAT_W-1:0] wr_status_q;
  logic              miso_q;
  logic [7:0]        last_cmd_q;
  logic [CNT_W-1:0]  op_count_q;
  logic [4:0]        irq_q;

  // ---------------- opcode decode ----------------
  logic [7:0] cmd_byte;
  logic       dec_hit;
  spis_op_e   dec_op;
  assign cmd_byte = {sh_q[6:0], mosi_s};
  spis_decode #(.NUM_OPS(4)) u_dec (
    .code_i(cmd_byte), .prog_en_i(cmd_prog_en), .prog_codes_i(cmd_codes_i),
    .hit_o(dec_hit), .op_o(dec_op)
  );

  // Settings of the operation being entered (CMD) or running (other states).
  spis_op_e         sel_op;
  logic [LEN_W-1:0] cur_alen, cur_dlen, cur_dum_len;
  logic             cur_dum_en;
  always_comb begin
    sel_op      = (state_q == ST_CMD) ? dec_op : op_q;
    cur_dum_en  = dummy_en_i[sel_op];
    cur_dum_len = LEN_W'(dummy_len_i[{sel_op, 3'b000} +: 8]);
    cur_alen    = (sel_op == OP_WRBUF) ? LEN_W'(wrbuf_alen_i) : LEN_W'(rdbuf_alen_i);
    case (sel_op)
      OP_WRBUF: cur_dlen = wrbuf_dlen_i;
      OP_RDBUF: cur_dlen = rdbuf_dlen_i;
      default:  cur_dlen = LEN_W'(STAT_W - 1);
    endcase
  end

  // Completion events, one per operation plus "any".
  logic       done_op;
  logic [4:0] done_vec;
  assign done_op = rise_w && (state_q == ST_DATA) && (cnt_q == cur_dlen);
  for (genvar k = 0; k < 4; k++) begin : g_done
    assign done_vec[k] = done_op && (op_q == spis_op_e'(k));
  end
  assign done_vec[4] = done_op;

  // Outgoing bit for the current data position.
  logic [STAT_W-1:0] rsta_src;
  logic [SW-1:0]     sidx;
  logic              rd_bit;
  assign rsta_src = sta_sel_wr_i ? wr_status_q : rd_status_i;
  assign sidx     = SW'(STAT_W - 1) - cnt_q[SW-1:0];
  assign rd_bit   = (op_q == OP_RDBUF) ? buf_q[buf_index(addr_q, cnt_q)] : rsta_src[sidx];

  spis_st_e after_addr;
  assign after_addr = cur_dum_en ? ST_DUMMY : ST_DATA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;      op_q <= OP_WRSTA;  cnt_q <= '0;
      sh_q <= '0;             addr_q <= '0;      buf_q <= '0;
      wr_status_q <= '0;      miso_q <= 1'b0;    last_cmd_q <= '0;
      op_count_q <= '0;       irq_q <= '0;       sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      irq_q  <= done_vec & int_en_i;
      if (cs_s) begin
        state_q <= ST_CMD;
        cnt_q   <= '0;
        miso_q  <= 1'b0;
      end else begin
        if (rise_w) begin
          case (state_q)
            ST_CMD: begin
              sh_q <= {sh_q[STAT_W-2:0], mosi_s};
              if (cnt_q == LEN_W'(7)) begin
                last_cmd_q <= cmd_byte;
                cnt_q      <= '0;
                addr_q     <= '0;
                op_q       <= dec_op;
                if (!dec_hit)                 state_q <= ST_END;
                else if (op_has_addr(dec_op)) state_q <= ST_ADDR;
                else                          state_q <= after_addr;
              end else cnt_q <= cnt_q + LEN_W'(1);
            end
            ST_ADDR: begin
              addr_q <= {addr_q[ADDR_W-2:0], mosi_s};
              if (cnt_q == cur_alen) begin
                cnt_q <= '0;  state_q <= after_addr;
              end else cnt_q <= cnt_q + LEN_W'(1);
            end
            ST_DUMMY: begin
              if (cnt_q == cur_dum_len) begin
                cnt_q <= '0;  state_q <= ST_DATA;
              end else cnt_q <= cnt_q + LEN_W'(1);
            end
            ST_DATA: begin
              sh_q <= {sh_q[STAT_W-2:0], mosi_s};
              if (op_q == OP_WRBUF) buf_q[buf_index(addr_q, cnt_q)] <= mosi_s;
              if (done_op) begin
                state_q    <= ST_END;
                op_count_q <= op_count_q + CNT_W'(1);
                if (op_q == OP_WRSTA) wr_status_q <= {sh_q[STAT_W-2:0], mosi_s};
              end else cnt_q <= cnt_q + LEN_W'(1);
            end
            default: ;
          endcase
        end
        if (fall_w) miso_q <= (state_q == ST_DATA) && op_is_read(op_q) && rd_bit;
      end
    end
  end

  assign spi_miso    = miso_q;
  assign irq_o       = irq_q;
  assign wr_status_o = wr_status_q;
  assign last_cmd_o  = last_cmd_q;
  assign op_count_o  = op_count_q;

  // ---------------- assertions ----------------
  assert_abort_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (state_q == ST_CMD) && !irq_q[4]);

  assert_miso_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso_q) |-> $past(fall_w || cs_s));

  assert_miso_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_q && !$past(fall_w)) |-> $past(miso_q));

  assert_one_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_vec[3:0]));

  assert_irq_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q & ~$past(int_en_i)) == 5'b0);

  assert_count_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(op_count_q) |-> $past(done_vec[4]));

  assert_status_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_status_q) |-> $past(done_vec[0]));

  assert_unknown_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_END) |=> !done_vec[4]);
endmodule

// File: tb/sim_spis_target.sv
module sim_spis_target;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sclk, cs_n, mosi, miso;
  logic cmd_prog_en, sta_sel_wr;
  logic [31:0] cmd_codes, dummy_len, rd_status, wr_status;
  logic [3:0]  dummy_en;
  logic [5:0]  wrbuf_alen, rdbuf_alen;
  logic [23:0] wrbuf_dlen, rdbuf_dlen;
  logic [4:0]  int_en, irq;
  logic [7:0]  last_cmd;
  logic [3:0]  op_count;

  spis_target u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .cmd_prog_en(cmd_prog_en), .cmd_codes_i(cmd_codes),
    .dummy_en_i(dummy_en), .dummy_len_i(dummy_len), .wrbuf_alen_i(wrbuf_alen),
    .rdbuf_alen_i(rdbuf_alen), .wrbuf_dlen_i(wrbuf_dlen), .rdbuf_dlen_i(rdbuf_dlen),
    .sta_sel_wr_i(sta_sel_wr), .rd_status_i(rd_status), .int_en_i(int_en),
    .irq_o(irq), .wr_status_o(wr_status), .last_cmd_o(last_cmd), .op_count_o(op_count)
  );

  int checks = 0, fails = 0, n_ops = 0;
  int irq_cnt [5];
  int snap [5];
  bit finished = 0;

  always @(negedge clk) begin
    for (int k = 0; k < 5; k++) if (irq[k]) irq_cnt[k]++;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic take_snap();
    for (int k = 0; k < 5; k++) snap[k] = irq_cnt[k];
  endtask

  task automatic check_irq(input string req, input int k, input int delta);
    check(req, 64'(irq_cnt[k] - snap[k]), 64'(delta));
  endtask

  task automatic spi_bits(input int n, input logic [63:0] tx, output logic [63:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  // Full window: opcode, optional address, dummy cycles (ones), data bits.
  task automatic txn(input logic [7:0] cmd, input int abits, input logic [63:0] addr,
                     input int dbits_dummy, input int nbits, input logic [63:0] tx,
                     output logic [63:0] rx);
    logic [63:0] junk;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_bits(8, 64'(cmd), junk);
    if (abits > 0) spi_bits(abits, addr, junk);
    if (dbits_dummy > 0) spi_bits(dbits_dummy, '1, junk);
    spi_bits(nbits, tx, rx);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  logic [63:0] rx;

  task automatic t_reset();
    check("R14 miso at reset", 64'(miso), 0);
    check("R11 count at reset", 64'(op_count), 0);
    check("R11 last_cmd at reset", 64'(last_cmd), 0);
    check("R10 irq at reset", 64'(irq), 0);
    check("R8 status at reset", 64'(wr_status), 0);
  endtask

  task automatic t_write_status();
    take_snap();
    txn(8'd1, 0, 0, 0, 32, 64'hA5C31E70, rx); n_ops++;
    check("R1 R2 R8 write-status value", 64'(wr_status), 64'hA5C31E70);
    check_irq("R10 wrsta irq", 0, 1);
    check_irq("R10 any irq", 4, 1);
    check("R11 count", 64'(op_count), 64'(n_ops % 16));
    check("R11 last_cmd", 64'(last_cmd), 1);
  endtask

  task automatic t_read_status();
    take_snap();
    sta_sel_wr = 1'b0;
    txn(8'd4, 0, 0, 0, 32, 0, rx); n_ops++;
    check("R9 read local status", rx & 64'hFFFFFFFF, 64'h1234ABCD);
    sta_sel_wr = 1'b1;
    txn(8'd4, 0, 0, 0, 32, 0, rx); n_ops++;
    check("R9 read written status", rx & 64'hFFFFFFFF, 64'hA5C31E70);
    check_irq("R10 rdsta irq", 3, 2);
    sta_sel_wr = 1'b0;
  endtask

  task automatic t_buffer();
    take_snap();
    wrbuf_alen = 6'd7; rdbuf_alen = 6'd7;
    wrbuf_dlen = 24'd23;
    txn(8'd2, 8, 64'h03, 0, 24, 64'hDEADBE, rx); n_ops++;
    rdbuf_dlen = 24'd7;
    txn(8'd3, 8, 64'h04, 0, 8, 0, rx); n_ops++;
    check("R6 R7 R4 byte 4", rx & 64'hFF, 64'hAD);
    rdbuf_dlen = 24'd23;
    txn(8'd3, 8, 64'h03, 0, 24, 0, rx); n_ops++;
    check("R7 three bytes", rx & 64'hFFFFFF, 64'hDEADBE);
    check_irq("R10 wrbuf irq", 1, 1);
    check_irq("R10 rdbuf irq", 2, 2);
  endtask

  task automatic t_wrap_and_len();
    wrbuf_alen = 6'd15; rdbuf_alen = 6'd15;
    wrbuf_dlen = 24'd15;
    txn(8'd2, 16, 64'hFF1F, 0, 16, 64'h1122, rx); n_ops++;
    rdbuf_dlen = 24'd15;
    txn(8'd3, 16, 64'h001F, 0, 16, 0, rx); n_ops++;
    check("R6 wrap across top byte", rx & 64'hFFFF, 64'h1122);
    rdbuf_dlen = 24'd7;
    txn(8'd3, 16, 64'h0000, 0, 8, 0, rx); n_ops++;
    check("R4 R6 wrapped byte 0", rx & 64'hFF, 64'h22);
    wrbuf_dlen = 24'd3;
    txn(8'd2, 16, 64'h000A, 0, 4, 64'hF, rx); n_ops++;
    txn(8'd3, 16, 64'h000A, 0, 8, 0, rx); n_ops++;
    check("R6 partial byte write", rx & 64'hFF, 64'hF0);
    wrbuf_alen = 6'd7; rdbuf_alen = 6'd7;
  endtask

  task automatic t_dummy();
    dummy_en  = 4'b0101;
    dummy_len = 32'h0003_0001;
    txn(8'd1, 0, 0, 2, 32, 64'h0F0F5A5A, rx); n_ops++;
    check("R5 dummy before write-status", 64'(wr_status), 64'h0F0F5A5A);
    rdbuf_dlen = 24'd7;
    txn(8'd3, 8, 64'h03, 4, 8, 0, rx); n_ops++;
    check("R5 dummy before read-buffer", rx & 64'hFF, 64'hDE);
    dummy_en = 4'b0000;
  endtask

  task automatic t_prog_cmds();
    take_snap();
    cmd_prog_en = 1'b1;
    cmd_codes = 32'h34333231;
    txn(8'd1, 0, 0, 0, 32, 64'hFFFFFFFF, rx);
    check("R3 R13 fixed code ignored", 64'(wr_status), 64'h0F0F5A5A);
    check("R13 count unchanged", 64'(op_count), 64'(n_ops % 16));
    check("R11 invalid code recorded", 64'(last_cmd), 1);
    txn(8'h31, 0, 0, 0, 32, 64'h600DF00D, rx); n_ops++;
    check("R3 programmed write-status", 64'(wr_status), 64'h600DF00D);
    sta_sel_wr = 1'b1;
    txn(8'h34, 0, 0, 0, 32, 0, rx); n_ops++;
    check("R3 R9 programmed read-status", rx & 64'hFFFFFFFF, 64'h600DF00D);
    check_irq("R10 two completions", 4, 2);
    sta_sel_wr = 1'b0;
    cmd_prog_en = 1'b0;
  endtask

  task automatic t_unknown();
    take_snap();
    txn(8'h77, 0, 0, 0, 40, 64'hAA55AA55AA, rx);
    check("R13 R14 miso stays low", rx & 64'hFFFFFFFFFF, 0);
    check_irq("R13 no irq", 4, 0);
    check("R13 count unchanged", 64'(op_count), 64'(n_ops % 16));
    check("R11 last_cmd unknown", 64'(last_cmd), 64'h77);
  endtask

  task automatic t_abort();
    take_snap();
    txn(8'd1, 0, 0, 0, 16, 64'hBEEF, rx);
    check("R12 status kept on abort", 64'(wr_status), 64'h600DF00D);
    check("R12 count kept on abort", 64'(op_count), 64'(n_ops % 16));
    check_irq("R12 no irq on abort", 0, 0);
    txn(8'd4, 0, 0, 0, 32, 0, rx); n_ops++;
    check("R12 next window works", rx & 64'hFFFFFFFF, 64'h1234ABCD);
  endtask

  task automatic t_irq_gate();
    take_snap();
    int_en = 5'b10101;
    wrbuf_dlen = 24'd7;
    txn(8'd2, 8, 64'h08, 0, 8, 64'h3C, rx); n_ops++;
    check_irq("R10 masked wrbuf irq", 1, 0);
    check_irq("R10 any irq still on", 4, 1);
    int_en = 5'h1F;
  endtask

  task automatic t_count_wrap();
    for (int i = 0; i < 10; i++) begin
      txn(8'd4, 0, 0, 0, 32, 0, rx); n_ops++;
    end
    check("R11 count wraps", 64'(op_count), 64'(n_ops % 16));
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    cmd_prog_en = 1'b0; cmd_codes = '0; dummy_en = '0; dummy_len = '0;
    wrbuf_alen = 6'd7; rdbuf_alen = 6'd7; wrbuf_dlen = 24'd7; rdbuf_dlen = 24'd7;
    sta_sel_wr = 1'b0; rd_status = 32'h1234ABCD; int_en = 5'h1F;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_status();
    t_read_status();
    t_buffer();
    t_wrap_and_len();
    t_dummy();
    t_prog_cmds();
    t_unknown();
    t_abort();
    t_irq_gate();
    t_count_wrap();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule